// File: doc/BRIEF.md
# Cluster Performance Counter Unit

This block counts activity for a shared processor cluster. It holds a parameterised set of 32-bit event counters and a dedicated 64-bit cycle counter. Each event counter is told by software which event code to follow. Event sources arrive as single-cycle pulses on a vector of lines, one line per event code. When any counter wraps, a sticky overflow flag is set. A level interrupt is raised for every flag whose interrupt enable is set.

Software reaches the block through a plain request port: valid, write, a 4-bit word address and 32 bits of data. Writes take effect on the clock edge that accepts the request. A read is answered one cycle later with a response strobe. Inside the port, a two-state access machine tracks whether a read response is owed. In `ST_IDLE` no response is pending. A read request moves it to `ST_RESP` (transition IDLE_TO_RESP), or keeps it there on back-to-back reads (RESP_HOLD). Any other cycle returns it to `ST_IDLE` (transitions RESP_TO_IDLE and IDLE_HOLD).

Word addresses:

| Address | Register |
|---|---|
| 0 | control |
| 1 | counter select |
| 2 | event type |
| 3 | counter value, low word |
| 4 | counter value, high word |
| 5 | enable set |
| 6 | enable clear |
| 7 | interrupt-enable set |
| 8 | interrupt-enable clear |
| 9 | overflow status |
| 10 | availability word, low |
| 11 | availability word, high |

Every other address reads 0.

Top module: `cluster_pmu`

## Requirements
- R1: Reading control returns the implementer code in bits 31:24 and the identification code in bits 23:16. Bits 15:11 hold the number of event counters (at most 31, cycle counter excluded). Bits 10:1 read 0, and bit 0 is the global enable. The action bits 1 and 2 always read 0.
- R2: While the global enable (control bit 0) is 0, no counter changes except through software writes, whatever the per-counter enables and event lines are.
- R3: An enabled event counter adds one on each clock in which the global enable is set and the line indexed by its 6-bit event type (event register bits 5:0) is high. Event type 0x11 counts every such clock, whatever the lines carry.
- R4: Writing 1s to enable-set sets per-counter enable bits, and writing 1s to enable-clear clears them. Both addresses read back the mask. Bit i belongs to event counter i and bit 31 to the cycle counter. Bits of unimplemented counters stay 0.
- R5: Select (bits 4:0) chooses the counter that the event-type and value registers access, and the event type and value read back what was written. Index 31 reports event type 0x11. An unimplemented index reads 0 and ignores writes.
- R6: A software write to a counter value takes priority over an increment in the same cycle.
- R7: An event counter that wraps from 0xFFFFFFFF to 0 sets its overflow bit and keeps counting.
- R8: The cycle counter is 64 bits wide. It is reached at index 31 through the low word (address 3) and the high word (address 4). When it wraps from all-ones it sets overflow bit 31.
- R9: Reading overflow status returns the pending flags and clears them. A wrap in the cycle of that read stays pending.
- R10: The interrupt output is high exactly when some overflow flag and its interrupt-enable bit (set at address 7, cleared at address 8) are both 1.
- R11: Writing control bit 1 zeroes all event counters, and writing control bit 2 zeroes the cycle counter.
- R12: The two availability words (addresses 10 and 11) read back their parameter values and ignore writes.
- R13: A read request is answered in the next cycle with rsp_valid high and the data. rsp_valid is low in any cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| evt_in | input | NUM_LINES | Event pulses, one line per event code |
| irq | output | 1 | Overflow interrupt, level |

## Verification
Writes, counter clears and enable changes are applied on the edge that accepts the request. A counter therefore first counts on the edge after an enable write, and still counts on the edge that accepts a disable write. For a gated window of W idle cycles between those two writes, the bench expects W+1 counts. Read data is captured on the accepting edge from pre-edge state, so it reflects everything up to the previous edge. The bench samples it at the following falling edge, together with rsp_valid. The interrupt follows the overflow register with no extra flop, so it is sampled one falling edge after the wrap or the clearing read.

// File: rtl/cpmu_pkg.sv
package cpmu_pkg;
    localparam int          EVT_W    = 6;
    localparam int          CYC_IDX  = 31;
    localparam logic [5:0]  CYC_CODE = 6'h11;

    typedef enum logic [3:0] {
        A_CTRL  = 4'd0,
        A_SEL   = 4'd1,
        A_TYPE  = 4'd2,
        A_VLO   = 4'd3,
        A_VHI   = 4'd4,
        A_ENSET = 4'd5,
        A_ENCLR = 4'd6,
        A_IESET = 4'd7,
        A_IECLR = 4'd8,
        A_OVF   = 4'd9,
        A_AVL0  = 4'd10,
        A_AVL1  = 4'd11
    } reg_addr_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } port_state_e;
endpackage

// File: rtl/cpmu_evt_counter.sv
module cpmu_evt_counter
    import cpmu_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 count_en,
    input  logic [NUM_LINES-1:0] evt_lines,
    input  logic                 type_we,
    input  logic                 val_we,
    input  logic                 zero,
    input  logic [31:0]          wdata,
    output logic [EVT_W-1:0]     evtype,
    output logic [31:0]          value,
    output logic                 wrap
);
    logic line_hit;
    logic hit;
    logic incr;

    // pick the line addressed by the event type
    always_comb begin
        line_hit = 1'b0;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (evtype == EVT_W'(k)) line_hit = evt_lines[k];
        end
    end

    assign hit  = (evtype == CYC_CODE) ? 1'b1 : line_hit;
    assign incr = count_en & hit;
    assign wrap = incr & ~zero & ~val_we & (value == 32'hFFFF_FFFF);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evtype <= '0;
            value  <= '0;
        end else begin
            if (type_we) evtype <= wdata[EVT_W-1:0];
            if (zero)        value <= '0;
            else if (val_we) value <= wdata;
            else if (incr)   value <= value + 32'd1;
        end
    end
endmodule

// File: rtl/cpmu_cyc_counter.sv
module cpmu_cyc_counter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        count_en,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic        zero,
    input  logic [31:0] wdata,
    output logic [63:0] value,
    output logic        wrap
);
    logic sw_touch;

    assign sw_touch = zero | wr_lo | wr_hi;
    assign wrap     = count_en & ~sw_touch & (value == 64'hFFFF_FFFF_FFFF_FFFF);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (zero) begin
            value <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) value[31:0]  <= wdata;
            if (wr_hi) value[63:32] <= wdata;
        end else if (count_en) begin
            value <= value + 64'd1;
        end
    end
endmodule

// File: rtl/cpmu_regif.sv
module cpmu_regif
    import cpmu_pkg::*;
#(
    parameter int          NUM_CNT   = 6,
    parameter logic [7:0]  ID_CODE   = 8'h5A,
    parameter logic [7:0]  IMPL_CODE = 8'hC3,
    parameter logic [31:0] AVAIL_LO  = 32'h260A_0000,
    parameter logic [31:0] AVAIL_HI  = 32'h0000_3C00
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [3:0]                  req_addr,
    input  logic [31:0]                 req_wdata,
    output logic                        rsp_valid,
    output logic [31:0]                 rsp_rdata,
    input  logic [NUM_CNT-1:0][31:0]    evt_val,
    input  logic [NUM_CNT-1:0][EVT_W-1:0] evt_type,
    input  logic [NUM_CNT-1:0]          evt_wrap,
    input  logic [63:0]                 cyc_val,
    input  logic                        cyc_wrap,
    output logic                        glob_en,
    output logic [31:0]                 cnten,
    output logic [31:0]                 inten,
    output logic [31:0]                 ovf,
    output logic                        irq,
    output logic [NUM_CNT-1:0]          type_we,
    output logic [NUM_CNT-1:0]          val_we,
    output logic                        cyc_wr_lo,
    output logic                        cyc_wr_hi,
    output logic                        zero_evt,
    output logic                        zero_cyc
);
    localparam logic [31:0] IMPL_MASK = {1'b1, 31'((32'd1 << NUM_CNT) - 32'd1)};
    localparam logic [4:0]  CNT_FIELD = 5'(NUM_CNT);

    logic        wr, rd;
    logic [4:0]  sel_q;
    logic        sel_cyc;
    logic [31:0] wrap_vec;
    logic [31:0] ovf_next;
    logic [31:0] rd_mux;
    logic [31:0] rdata_q;
    logic [31:0] sel_val;
    logic [EVT_W-1:0] sel_type;
    port_state_e state_q, state_d;

    assign wr      = req_valid &  req_write;
    assign rd      = req_valid & ~req_write;
    assign sel_cyc = (sel_q == 5'(CYC_IDX));

    // write strobes toward the counters
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_strobe
        assign type_we[i] = wr && (req_addr == A_TYPE) && (sel_q == 5'(i));
        assign val_we[i]  = wr && (req_addr == A_VLO)  && (sel_q == 5'(i));
    end
    assign cyc_wr_lo = wr && (req_addr == A_VLO) && sel_cyc;
    assign cyc_wr_hi = wr && (req_addr == A_VHI) && sel_cyc;
    assign zero_evt  = wr && (req_addr == A_CTRL) && req_wdata[1];
    assign zero_cyc  = wr && (req_addr == A_CTRL) && req_wdata[2];

    // overflow flags: read clears, a simultaneous wrap survives
    always_comb begin
        wrap_vec = '0;
        for (int i = 0; i < NUM_CNT; i++) wrap_vec[i] = evt_wrap[i];
        wrap_vec[CYC_IDX] = cyc_wrap;
        ovf_next = ((rd && req_addr == A_OVF) ? 32'd0 : ovf) | wrap_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            sel_q   <= '0;
            cnten   <= '0;
            inten   <= '0;
            ovf     <= '0;
        end else begin
            ovf <= ovf_next;
            if (wr) begin
                case (req_addr)
                    A_CTRL:  glob_en <= req_wdata[0];
                    A_SEL:   sel_q   <= req_wdata[4:0];
                    A_ENSET: cnten   <= cnten | (req_wdata & IMPL_MASK);
                    A_ENCLR: cnten   <= cnten & ~req_wdata;
                    A_IESET: inten   <= inten | (req_wdata & IMPL_MASK);
                    A_IECLR: inten   <= inten & ~req_wdata;
                    default: ;
                endcase
            end
        end
    end

    // selected counter view
    always_comb begin
        sel_val  = '0;
        sel_type = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (sel_q == 5'(i)) begin
                sel_val  = evt_val[i];
                sel_type = evt_type[i];
            end
        end
    end

    always_comb begin
        case (req_addr)
            A_CTRL:  rd_mux = {IMPL_CODE, ID_CODE, CNT_FIELD, 10'd0, glob_en};
            A_SEL:   rd_mux = {27'd0, sel_q};
            A_TYPE:  rd_mux = sel_cyc ? {26'd0, CYC_CODE} : {26'd0, sel_type};
            A_VLO:   rd_mux = sel_cyc ? cyc_val[31:0] : sel_val;
            A_VHI:   rd_mux = sel_cyc ? cyc_val[63:32] : 32'd0;
            A_ENSET, A_ENCLR: rd_mux = cnten;
            A_IESET, A_IECLR: rd_mux = inten;
            A_OVF:   rd_mux = ovf;
            A_AVL0:  rd_mux = AVAIL_LO;
            A_AVL1:  rd_mux = AVAIL_HI;
            default: rd_mux = 32'd0;
        endcase
    end

    // access state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd) rdata_q <= rd_mux;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd ? ST_RESP : ST_IDLE;
        endcase
    end

    // access state machine: outputs
    always_comb begin
        rsp_valid = (state_q == ST_RESP);
        rsp_rdata = rsp_valid ? rdata_q : 32'd0;
        irq       = |(ovf & inten);
    end
endmodule

// File: rtl/cluster_pmu.sv
module cluster_pmu
    import cpmu_pkg::*;
#(
    parameter int          NUM_EVT_CNT = 6,
    parameter int          NUM_LINES   = 64,
    parameter logic [7:0]  ID_CODE     = 8'h5A,
    parameter logic [7:0]  IMPL_CODE   = 8'hC3,
    parameter logic [31:0] AVAIL_LO    = 32'h260A_0000,
    parameter logic [31:0] AVAIL_HI    = 32'h0000_3C00
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [3:0]           req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    input  logic [NUM_LINES-1:0] evt_in,
    output logic                 irq
);
    logic [NUM_EVT_CNT-1:0][31:0]      evt_val;
    logic [NUM_EVT_CNT-1:0][EVT_W-1:0] evt_type;
    logic [NUM_EVT_CNT-1:0]            evt_wrap;
    logic [NUM_EVT_CNT-1:0]            type_we;
    logic [NUM_EVT_CNT-1:0]            val_we;
    logic [63:0] cyc_val;
    logic        cyc_wrap;
    logic        glob_en;
    logic [31:0] cnten;
    logic [31:0] inten;
    logic [31:0] ovf;
    logic        cyc_wr_lo, cyc_wr_hi;
    logic        zero_evt, zero_cyc;

    cpmu_regif #(
        .NUM_CNT  (NUM_EVT_CNT),
        .ID_CODE  (ID_CODE),
        .IMPL_CODE(IMPL_CODE),
        .AVAIL_LO (AVAIL_LO),
        .AVAIL_HI (AVAIL_HI)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .evt_val  (evt_val),
        .evt_type (evt_type),
        .evt_wrap (evt_wrap),
        .cyc_val  (cyc_val),
        .cyc_wrap (cyc_wrap),
        .glob_en  (glob_en),
        .cnten    (cnten),
        .inten    (inten),
        .ovf      (ovf),
        .irq      (irq),
        .type_we  (type_we),
        .val_we   (val_we),
        .cyc_wr_lo(cyc_wr_lo),
        .cyc_wr_hi(cyc_wr_hi),
        .zero_evt (zero_evt),
        .zero_cyc (zero_cyc)
    );

    for (genvar i = 0; i < NUM_EVT_CNT; i++) begin : g_evt
        cpmu_evt_counter #(.NUM_LINES(NUM_LINES)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_en (glob_en & cnten[i]),
            .evt_lines(evt_in),
            .type_we  (type_we[i]),
            .val_we   (val_we[i]),
            .zero     (zero_evt),
            .wdata    (req_wdata),
            .evtype   (evt_type[i]),
            .value    (evt_val[i]),
            .wrap     (evt_wrap[i])
        );
    end

    cpmu_cyc_counter u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(glob_en & cnten[CYC_IDX]),
        .wr_lo   (cyc_wr_lo),
        .wr_hi   (cyc_wr_hi),
        .zero    (zero_cyc),
        .wdata   (req_wdata),
        .value   (cyc_val),
        .wrap    (cyc_wrap)
    );
endmodule

// File: rtl/cpmu_checker.sv
module cpmu_checker #(
    parameter int NUM_EVT_CNT = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_write,
    input logic [3:0]              req_addr,
    input logic [31:0]             req_wdata,
    input logic                    rsp_valid,
    input logic                    irq,
    input logic                    glob_en,
    input logic [31:0]             inten,
    input logic [31:0]             ovf,
    input logic [63:0]             cyc_val,
    input logic [NUM_EVT_CNT*32-1:0] evt_flat
);
    assert_rsp_due_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_rsp_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !(req_valid && req_write)) |=> ($stable(evt_flat) && $stable(cyc_val)));

    assert_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inten == 32'd0) |-> !irq);

    assert_cyc_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cyc_val) == 64'hFFFF_FFFF_FFFF_FFFF) && (cyc_val == 64'd0)
         && !$past(req_valid && req_write)) |-> ovf[31]);

    assert_cyc_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 4'd0 && req_wdata[2]) |=> (cyc_val == 64'd0));
endmodule

bind cluster_pmu cpmu_checker #(.NUM_EVT_CNT(NUM_EVT_CNT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .irq      (irq),
    .glob_en  (glob_en),
    .inten    (inten),
    .ovf      (ovf),
    .cyc_val  (cyc_val),
    .evt_flat (evt_val)
);

// File: tb/cluster_pmu_test.sv
module cluster_pmu_test;
    localparam int          N    = 6;
    localparam int          NL   = 64;
    localparam logic [7:0]  IDC  = 8'h5A;
    localparam logic [7:0]  IMPC = 8'hC3;
    localparam logic [31:0] AV0  = 32'h260A_0000;
    localparam logic [31:0] AV1  = 32'h0000_3C00;

    localparam logic [3:0] CTRL = 0, SEL = 1, TYP = 2, VLO = 3, VHI = 4,
                           ENS = 5, ENC = 6, IES = 7, IEC = 8, OVF = 9,
                           AW0 = 10, AW1 = 11;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [3:0]  req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NL-1:0] evt_in = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    cluster_pmu #(
        .NUM_EVT_CNT(N), .NUM_LINES(NL), .ID_CODE(IDC), .IMPL_CODE(IMPC),
        .AVAIL_LO(AV0), .AVAIL_HI(AV1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .evt_in(evt_in), .irq(irq)
    );

    function automatic logic [31:0] ctrl_expect(input logic en);
        return {IMPC, IDC, 5'(N), 10'd0, en};
    endfunction

    function automatic logic [31:0] impl_mask();
        return {1'b1, 31'((32'd1 << N) - 32'd1)};
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    logic last_rsp;
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        req_valid = 1; req_write = 0; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        d = rsp_rdata;
        last_rsp = rsp_valid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int e0, e1;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state
        check("R10 reset irq", irq, 0);
        rd(CTRL, d);
        check("R1 ctrl reset", d, ctrl_expect(0));
        check("R13 rsp after read", last_rsp, 1);
        @(negedge clk);
        check("R13 rsp idle", rsp_valid, 0);
        rd(OVF, d);
        check("R9 reset ovf", d, 0);
        rd(AW0, d); check("R12 avail low", d, AV0);
        wr(AW1, 32'hFFFF_FFFF);
        rd(AW1, d); check("R12 avail high", d, AV1);

        // select / type / value readback
        wr(SEL, 0); wr(TYP, 32'h3);
        rd(TYP, d); check("R5 type readback", d, 3);
        for (int i = 0; i < 8; i++) begin
            int idx;
            logic [31:0] v;
            idx = $urandom % N;
            v = $urandom;
            wr(SEL, idx); wr(VLO, v);
            rd(VLO, d); check("R5 random value readback", d, v);
        end
        wr(SEL, 10); wr(VLO, 32'hDEAD); wr(TYP, 32'h7);
        rd(VLO, d); check("R5 unimplemented value", d, 0);
        rd(TYP, d); check("R5 unimplemented type", d, 0);
        wr(SEL, 31);
        rd(TYP, d); check("R5 cycle type", d, 32'h11);

        // enable masks
        wr(ENS, 32'hFFFF_FFFF);
        rd(ENS, d); check("R4 enable set", d, impl_mask());
        wr(ENC, 32'h8000_003C);
        rd(ENC, d); check("R4 enable clear", d, 32'h3);

        // global enable off
        wr(SEL, 0); wr(TYP, 3); wr(VLO, 0);
        wr(SEL, 1); wr(TYP, 5); wr(VLO, 0);
        evt_in = '1;
        repeat (10) @(negedge clk);
        evt_in = '0;
        wr(SEL, 0); rd(VLO, d); check("R2 gated counter0", d, 0);
        wr(SEL, 1); rd(VLO, d); check("R2 gated counter1", d, 0);

        // random event counting
        e0 = 0; e1 = 0;
        wr(CTRL, 1);
        for (int i = 0; i < 200; i++) begin
            evt_in = {$urandom, $urandom};
            if (evt_in[3]) e0++;
            if (evt_in[5]) e1++;
            @(negedge clk);
        end
        evt_in = '0;
        wr(CTRL, 0);
        wr(SEL, 0); rd(VLO, d); check("R3 random count0", d, e0);
        wr(SEL, 1); rd(VLO, d); check("R3 random count1", d, e1);

        // code 0x11 counts each clock: W idle cycles give W+1 counts
        wr(ENC, 32'hFFFF_FFFF);
        wr(SEL, 2); wr(TYP, 32'h11); wr(VLO, 0);
        wr(ENS, 32'h4);
        wr(CTRL, 1);
        repeat (20) @(negedge clk);
        wr(CTRL, 0);
        rd(VLO, d); check("R3 cycle code count", d, 21);

        // write beats increment
        wr(CTRL, 1);
        wr(VLO, 100);
        rd(VLO, d); check("R6 write priority", d, 100);

        // wrap in the cycle of the status read
        rd(OVF, d);
        wr(VLO, 32'hFFFF_FFFF);
        rd(OVF, d); check("R9 read during wrap", d, 0);
        rd(OVF, d); check("R9 wrap kept pending", d, 32'h4);
        rd(OVF, d); check("R9 cleared by read", d, 0);
        wr(CTRL, 0);
        rd(VLO, d); check("R7 counts after wrap", d, 3);

        // interrupt
        wr(VLO, 32'hFFFF_FFFF);
        wr(IES, 32'h4);
        wr(CTRL, 1);
        wr(CTRL, 0);
        check("R10 irq raised", irq, 1);
        rd(OVF, d); check("R7 overflow flag", d, 32'h4);
        check("R10 irq dropped", irq, 0);
        wr(IEC, 32'h4);

        // cycle counter
        wr(ENC, 32'hFFFF_FFFF);
        wr(ENS, 32'h8000_0000);
        wr(SEL, 31);
        wr(VHI, 32'hFFFF_FFFF); wr(VLO, 32'hFFFF_FFFD);
        rd(VHI, d); check("R8 high word", d, 32'hFFFF_FFFF);
        wr(CTRL, 1);
        repeat (4) @(negedge clk);
        wr(CTRL, 0);
        rd(VLO, d); check("R8 low after wrap", d, 2);
        rd(VHI, d); check("R8 high after wrap", d, 0);
        rd(OVF, d); check("R8 overflow bit31", d, 32'h8000_0000);

        // clear actions
        wr(CTRL, 32'h4);
        rd(VLO, d); check("R11 cycle cleared", d, 0);
        wr(SEL, 0);
        rd(VLO, d); check("R11 counter0 before clear", d, e0);
        wr(CTRL, 32'h7);
        rd(CTRL, d); check("R1 action bits read 0", d, ctrl_expect(1));
        wr(CTRL, 0);
        rd(VLO, d); check("R11 counter0 cleared", d, 0);
        wr(SEL, 2);
        rd(VLO, d); check("R11 counter2 cleared", d, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule